// File: doc/BRIEF.md
# Capture/Compare Channel Bank with Prioritised Interrupt Vector

This block holds a parameterised number of capture/compare channels that all observe one shared count value produced elsewhere. Each channel owns a 16-bit control word and a data register. In capture mode a channel samples the count into its data register when its input shows a selected edge. In compare mode it raises its flag when the count, qualified by a count-valid tick, equals its data register. A channel's input comes either from an external pin, after a two-flop synchroniser, or from a level that software writes into the control word.

A vector register reports the highest-priority pending source. Channels are scanned from the lowest index, then the externally supplied counter-overflow flag. Reading or writing the vector acknowledges the source it reported. Channel 0 has its own interrupt line, cleared by a dedicated acknowledge input. All other channels and the counter overflow share a second line. A small register bus gives access to the control words, the data registers and the vector.

Top module: `capcmp_vec`

## Requirements
- R1: A channel with bit 8 of its control word set captures on a rising input edge when bit 14 is set and on a falling edge when bit 15 is set. Both bits may be set at once, and an edge whose bit is clear is ignored. A pin edge reaches the channel through two synchroniser flops plus one level register.
- R2: On a qualifying capture edge with flag bit 0 clear, the current count is written into the channel's data register and bit 0 is set.
- R3: On a qualifying capture edge with bit 0 already set, overflow bit 1 is set and the data register keeps its earlier capture.
- R4: Bit 3 of a control word always reads the channel's current input level and cannot be written. While bit 13 is set, the input pin has no effect on the channel.
- R5: Writing a control word with bits 8 and 13 both set drives the channel input from bit 12 of the written value. An edge against the previous level then counts as a capture edge.
- R6: A channel with bit 8 clear sets bit 0 in a cycle where cnt_tick is high and the count equals its data register, and copies its input level into bit 10.
- R7: With EXT=0, bus writes leave bits 10, 9 and 3 of a control word unchanged. With EXT=1, only bit 3 is protected.
- R8: Address i (below 8) selects control word i, address 8+i selects data register i, and address 15 selects the vector. The vector is twice the lowest channel index whose enable bit 4 and flag bit 0 are both set. If no channel qualifies, an enabled pending overflow gives 0x000A (EXT=0) or 0x000E (EXT=1). Otherwise the vector is 0.
- R9: A read or write of the vector clears the flag of the channel it reported, except channel 0. When the overflow is reported, ovf_ack is high during that access.
- R10: irq_ch0 is high while channel 0 is enabled and flagged, and irq0_ack clears the channel-0 flag. irq_shared is high while any other channel is enabled and flagged, or the overflow is pending and enabled. Nothing clears it automatically.
- R11: A capture or compare event that sets a flag wins over a bus write or clear to that flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count | input | CNT_W | Shared count value |
| cnt_tick | input | 1 | Count valid for compare this cycle |
| cap_pin | input | NUM_CH | Asynchronous capture inputs, one per channel |
| ovf_flag | input | 1 | Counter overflow pending |
| ovf_en | input | 1 | Counter overflow interrupt enable |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write access |
| bus_rd | input | 1 | Read access |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| ovf_ack | output | 1 | Overflow reported by a vector access |
| iv_code | output | 16 | Current vector value |
| irq_ch0 | output | 1 | Channel-0 interrupt request |
| irq_shared | output | 1 | Shared interrupt request |
| irq0_ack | input | 1 | Acknowledge for the channel-0 request |

## Verification
A corrupted flag shows at once on irq_ch0, irq_shared and iv_code, in the cycle after the faulty edge. A wrong input level appears in bit 3 of the control word and later as a missed, spurious or overflowing capture. A capture that loses the count shows only when the data register is read back, so every capture scenario reads its data register right after the event. Vector clears are checked one access later, through the control word and the interrupt lines. That makes a missing clear or a wrongly cleared channel 0 visible within two cycles.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
   localparam int CTL_W   = 16;
   localparam int B_FLAG  = 0;
   localparam int B_COV   = 1;
   localparam int B_LVL   = 3;
   localparam int B_IE    = 4;
   localparam int B_CAP   = 8;
   localparam int B_SCS   = 9;
   localparam int B_LATCH = 10;
   localparam int B_SWV   = 12;
   localparam int B_SWSEL = 13;
   localparam int B_RISE  = 14;
   localparam int B_FALL  = 15;
   localparam logic [3:0] VEC_ADDR = 4'hF;

   function automatic logic [CTL_W-1:0] keep_mask(input bit ext);
      logic [CTL_W-1:0] m;
      m = '0;
      m[B_LVL] = 1'b1;
      if (!ext) begin
         m[B_LATCH] = 1'b1;
         m[B_SCS]   = 1'b1;
      end
      return m;
   endfunction

   function automatic logic [15:0] ovf_code(input bit ext);
      return ext ? 16'h000E : 16'h000A;
   endfunction
endpackage

// File: rtl/capcmp_sync.sv
module capcmp_sync #(
   parameter int WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         q    <= '0;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/capcmp_chan.sv
module capcmp_chan
   import capcmp_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter bit EXT   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_s,
   input  logic [CNT_W-1:0] count,
   input  logic             tick,
   input  logic             ctl_wr,
   input  logic             dat_wr,
   input  logic [15:0]      wdata,
   input  logic             vec_clr,
   input  logic             ack_clr,
   output logic [CTL_W-1:0] ctl_o,
   output logic [CNT_W-1:0] dat_o
);
   localparam logic [CTL_W-1:0] KEEP = keep_mask(EXT);

   logic [CTL_W-1:0] ctl_q, ctl_n;
   logic [CNT_W-1:0] dat_q, dat_n;
   logic             lvl_q, lvl_n;
   logic             rise, fall, cap_ev, cmp_ev;

   always_comb begin
      ctl_n = ctl_q;
      dat_n = dat_q;
      if (ctl_wr) ctl_n = (wdata & ~KEEP) | (ctl_q & KEEP);
      if (dat_wr) dat_n = wdata[CNT_W-1:0];
      if (vec_clr || ack_clr) ctl_n[B_FLAG] = 1'b0;

      // input source: software level on a select write, held while selected
      if (ctl_wr && wdata[B_CAP] && wdata[B_SWSEL]) lvl_n = wdata[B_SWV];
      else if (ctl_n[B_SWSEL])                      lvl_n = lvl_q;
      else                                          lvl_n = pin_s;

      rise   = !lvl_q && lvl_n;
      fall   = lvl_q && !lvl_n;
      cap_ev = ctl_n[B_CAP] && ((rise && ctl_n[B_RISE]) || (fall && ctl_n[B_FALL]));
      cmp_ev = !ctl_q[B_CAP] && tick && (count == dat_q);

      // events are applied last so they win over writes and clears
      if (cap_ev) begin
         if (ctl_q[B_FLAG]) ctl_n[B_COV] = 1'b1;
         else begin
            dat_n          = count;
            ctl_n[B_FLAG]  = 1'b1;
         end
      end
      if (cmp_ev) begin
         ctl_n[B_FLAG]  = 1'b1;
         ctl_n[B_LATCH] = lvl_q;
      end
      ctl_n[B_LVL] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         dat_q <= '0;
         lvl_q <= 1'b0;
      end else begin
         ctl_q <= ctl_n;
         dat_q <= dat_n;
         lvl_q <= lvl_n;
      end
   end

   always_comb begin
      ctl_o        = ctl_q;
      ctl_o[B_LVL] = lvl_q;
   end
   assign dat_o = dat_q;
endmodule

// File: rtl/capcmp_prio.sv
module capcmp_prio
   import capcmp_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter bit EXT    = 1'b0
) (
   input  logic [NUM_CH-1:0] pend,
   input  logic              ovf_pend,
   output logic [15:0]       code,
   output logic [NUM_CH-1:0] hit,
   output logic              hit_ovf
);
   always_comb begin
      code    = '0;
      hit     = '0;
      hit_ovf = 1'b0;
      if (ovf_pend) begin
         code    = ovf_code(EXT);
         hit_ovf = 1'b1;
      end
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (pend[i]) begin
            code    = 16'(2 * i);
            hit     = '0;
            hit[i]  = 1'b1;
            hit_ovf = 1'b0;
         end
      end
   end
endmodule

// File: rtl/capcmp_vec.sv
module capcmp_vec
   import capcmp_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 16,
   parameter bit EXT    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  count,
   input  logic              cnt_tick,
   input  logic [NUM_CH-1:0] cap_pin,
   input  logic              ovf_flag,
   input  logic              ovf_en,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [3:0]        bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              ovf_ack,
   output logic [15:0]       iv_code,
   output logic              irq_ch0,
   output logic              irq_shared,
   input  logic              irq0_ack
);
   initial begin
      assert (NUM_CH >= 2 && NUM_CH <= 7) else $fatal(1, "NUM_CH must be 2..7");
      assert (CNT_W >= 1 && CNT_W <= 16) else $fatal(1, "CNT_W must be 1..16");
   end

   logic [NUM_CH-1:0]            pin_s;
   logic [NUM_CH-1:0][CTL_W-1:0] ctl_a;
   logic [NUM_CH-1:0][CNT_W-1:0] dat_a;
   logic [NUM_CH-1:0]            ctl_wr_v, dat_wr_v, pend, hit;
   logic                         hit_ovf, vec_acc, ovf_pend;

   capcmp_sync #(.WIDTH(NUM_CH)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(cap_pin), .q(pin_s)
   );

   assign vec_acc  = bus_sel && (bus_wr || bus_rd) && (bus_addr == VEC_ADDR);
   assign ovf_pend = ovf_flag && ovf_en;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic vclr, aclr;
      assign ctl_wr_v[i] = bus_sel && bus_wr && (bus_addr == {1'b0, 3'(i)});
      assign dat_wr_v[i] = bus_sel && bus_wr && (bus_addr == {1'b1, 3'(i)});
      if (i == 0) begin : g_first
         assign vclr = 1'b0;
         assign aclr = irq0_ack;
      end else begin : g_rest
         assign vclr = vec_acc && hit[i];
         assign aclr = 1'b0;
      end
      capcmp_chan #(.CNT_W(CNT_W), .EXT(EXT)) u_chan (
         .clk(clk), .rst_n(rst_n), .pin_s(pin_s[i]), .count(count),
         .tick(cnt_tick), .ctl_wr(ctl_wr_v[i]), .dat_wr(dat_wr_v[i]),
         .wdata(bus_wdata), .vec_clr(vclr), .ack_clr(aclr),
         .ctl_o(ctl_a[i]), .dat_o(dat_a[i])
      );
      assign pend[i] = ctl_a[i][B_IE] && ctl_a[i][B_FLAG];
   end

   capcmp_prio #(.NUM_CH(NUM_CH), .EXT(EXT)) u_prio (
      .pend(pend), .ovf_pend(ovf_pend), .code(iv_code), .hit(hit), .hit_ovf(hit_ovf)
   );

   assign ovf_ack    = vec_acc && hit_ovf;
   assign irq_ch0    = pend[0];
   assign irq_shared = (|pend[NUM_CH-1:1]) || ovf_pend;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == VEC_ADDR) bus_rdata = iv_code;
      else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr[2:0] == 3'(i)) begin
               if (bus_addr[3]) bus_rdata = 16'(dat_a[i]);
               else             bus_rdata = ctl_a[i];
            end
         end
      end
   end
endmodule

// File: rtl/capcmp_vec_chk.sv
module capcmp_vec_chk
   import capcmp_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 16,
   parameter bit EXT    = 1'b0
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [NUM_CH-1:0][CTL_W-1:0] ctl_a,
   input logic [NUM_CH-1:0][CNT_W-1:0] dat_a,
   input logic [NUM_CH-1:0]            ctl_wr_v,
   input logic [NUM_CH-1:0]            dat_wr_v,
   input logic                         cnt_tick,
   input logic                         irq0_ack,
   input logic [15:0]                  iv_code
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_p
      // R3: overflow only rises over an already-set flag, and the capture is kept
      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(ctl_a[i][B_COV]) && !$past(ctl_wr_v[i]) && !$past(dat_wr_v[i]))
         |-> ($past(ctl_a[i][B_FLAG]) && $stable(dat_a[i])));
      // R6: a compare-mode flag only appears after a count tick
      p_cmp_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(ctl_a[i][B_FLAG]) && !$past(ctl_wr_v[i]) && !$past(ctl_a[i][B_CAP]))
         |-> $past(cnt_tick));
   end

   // R9/R10: the channel-0 flag survives everything but its acknowledge or a write
   p_ch0_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_a[0][B_FLAG] && !irq0_ack && !ctl_wr_v[0]) |=> ctl_a[0][B_FLAG]);

   // R8: only legal vector values
   p_vec_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (iv_code == 16'h0) || (iv_code == ovf_code(EXT)) ||
      (!iv_code[0] && (iv_code < 16'(2 * NUM_CH))));
endmodule

bind capcmp_vec capcmp_vec_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .EXT(EXT)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_a(ctl_a), .dat_a(dat_a), .ctl_wr_v(ctl_wr_v),
   .dat_wr_v(dat_wr_v), .cnt_tick(cnt_tick), .irq0_ack(irq0_ack), .iv_code(iv_code)
);

// File: tb/sim_capcmp_vec.sv
module sim_capcmp_vec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] count = '0;
   logic        cnt_tick = 1'b0;
   logic [2:0]  cap_pin = '0;
   logic        ovf_flag = 1'b0, ovf_en = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata, iv_code;
   logic        ovf_ack, irq_ch0, irq_shared;
   logic        irq0_ack = 1'b0;

   always #5 clk = ~clk;

   capcmp_vec #(.NUM_CH(3), .CNT_W(16), .EXT(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .count(count), .cnt_tick(cnt_tick), .cap_pin(cap_pin),
      .ovf_flag(ovf_flag), .ovf_en(ovf_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ovf_ack(ovf_ack), .iv_code(iv_code), .irq_ch0(irq_ch0), .irq_shared(irq_shared),
      .irq0_ack(irq0_ack)
   );

   typedef struct {
      bit          is_irq;
      logic [15:0] exp;
      logic        exp_ack;
      string       tag;
   } item_t;

   item_t sb_q[$];
   logic  probe = 1'b0;
   int    n_chk = 0, n_fail = 0;
   bit    done = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard away from the active edge
   always @(negedge clk) begin
      if (probe) begin
         if (sb_q.size() == 0) check(1'b0, "scoreboard empty", 16'h0, 16'h0);
         else begin
            item_t it;
            it = sb_q.pop_front();
            if (it.is_irq)
               check({14'h0, irq_ch0, irq_shared} == it.exp, it.tag,
                     {14'h0, irq_ch0, irq_shared}, it.exp);
            else begin
               check(bus_rdata == it.exp, it.tag, bus_rdata, it.exp);
               check(ovf_ack == it.exp_ack, {it.tag, " ack"}, {15'h0, ovf_ack}, {15'h0, it.exp_ack});
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
      @(posedge clk); #2;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #2;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic expect_rd(input logic [3:0] a, input logic [15:0] e, input logic ack, input string tag);
      item_t it;
      it.is_irq = 1'b0; it.exp = e; it.exp_ack = ack; it.tag = tag;
      @(posedge clk); #2;
      sb_q.push_back(it);
      bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a; probe = 1'b1;
      @(posedge clk); #2;
      bus_sel = 1'b0; bus_rd = 1'b0; probe = 1'b0;
   endtask

   task automatic expect_irq(input logic i0, input logic ish, input string tag);
      item_t it;
      it.is_irq = 1'b1; it.exp = {14'h0, i0, ish}; it.exp_ack = 1'b0; it.tag = tag;
      @(posedge clk); #2;
      sb_q.push_back(it);
      probe = 1'b1;
      @(posedge clk); #2;
      probe = 1'b0;
   endtask

   initial begin
      idle(20000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle(4); #2; rst_n = 1'b1;
      // reset state
      expect_rd(4'h0, 16'h0000, 1'b0, "R8 reset ctl0");
      expect_rd(4'hF, 16'h0000, 1'b0, "R8 reset vector");
      expect_irq(1'b0, 1'b0, "R10 reset irq");

      // R1/R2 rising capture on channel 1
      bus_write(4'h1, 16'h4110);
      count = 16'h1234; cap_pin[1] = 1'b1;
      idle(4);
      expect_irq(1'b0, 1'b1, "R10 shared after ch1 capture");
      expect_rd(4'h9, 16'h1234, 1'b0, "R2 ch1 data");
      expect_rd(4'h1, 16'h4119, 1'b0, "R2 ch1 flag and R4 level");
      expect_rd(4'hF, 16'h0002, 1'b0, "R8 vector ch1");
      expect_rd(4'h1, 16'h4118, 1'b0, "R9 ch1 flag cleared by vector read");
      expect_irq(1'b0, 1'b0, "R10 shared dropped");
      cap_pin[1] = 1'b0; idle(4);
      expect_rd(4'h1, 16'h4110, 1'b0, "R1 falling edge ignored when only rise enabled");

      // R1/R3 both edges and capture overflow
      bus_write(4'h1, 16'hC110);
      count = 16'h2222; cap_pin[1] = 1'b1; idle(4);
      count = 16'h3333; cap_pin[1] = 1'b0; idle(4);
      expect_rd(4'h1, 16'hC113, 1'b0, "R3 overflow bit set");
      expect_rd(4'h9, 16'h2222, 1'b0, "R3 first capture kept");
      bus_write(4'h1, 16'hC110);
      expect_rd(4'h1, 16'hC110, 1'b0, "R3 flags cleared by write");

      // R5 software capture, R4 pin ignored while software-selected
      count = 16'h0555;
      bus_write(4'h2, 16'h7110);
      expect_rd(4'hA, 16'h0555, 1'b0, "R5 software capture data");
      expect_rd(4'h2, 16'h7119, 1'b0, "R5 software capture flag");
      cap_pin[2] = 1'b1; idle(4); cap_pin[2] = 1'b0; idle(4);
      expect_rd(4'h2, 16'h7119, 1'b0, "R4 pin ignored under software select");
      expect_rd(4'hA, 16'h0555, 1'b0, "R4 data untouched by pin");

      // R6 compare on channel 0
      bus_write(4'h8, 16'h0042);
      bus_write(4'h0, 16'h0010);
      cap_pin[0] = 1'b1; idle(4);
      count = 16'h0042;
      @(posedge clk); #2; cnt_tick = 1'b1;
      @(posedge clk); #2; cnt_tick = 1'b0;
      expect_rd(4'h0, 16'h0419, 1'b0, "R6 compare flag and latched level");
      expect_irq(1'b1, 1'b1, "R10 both lines");
      expect_rd(4'hF, 16'h0000, 1'b0, "R8 ch0 wins over ch2");
      expect_rd(4'h0, 16'h0419, 1'b0, "R9 ch0 flag kept after vector read");
      @(posedge clk); #2; irq0_ack = 1'b1;
      @(posedge clk); #2; irq0_ack = 1'b0;
      expect_rd(4'h0, 16'h0418, 1'b0, "R10 ack clears ch0 flag");
      expect_irq(1'b0, 1'b1, "R10 ch0 line dropped");

      // R7 write protection of bits 10 and 9
      bus_write(4'h0, 16'h0010);
      expect_rd(4'h0, 16'h0418, 1'b0, "R7 bit10 protected");
      bus_write(4'h0, 16'h0210);
      expect_rd(4'h0, 16'h0418, 1'b0, "R7 bit9 protected");
      expect_rd(4'hF, 16'h0004, 1'b0, "R8 vector ch2");
      expect_rd(4'h2, 16'h7118, 1'b0, "R9 ch2 flag cleared");

      // R8/R9 counter overflow source
      ovf_flag = 1'b1; ovf_en = 1'b0;
      expect_rd(4'hF, 16'h0000, 1'b0, "R8 disabled overflow not reported");
      expect_irq(1'b0, 1'b0, "R10 disabled overflow no request");
      ovf_en = 1'b1;
      expect_irq(1'b0, 1'b1, "R10 overflow on shared line");
      expect_rd(4'hF, 16'h000A, 1'b1, "R9 overflow vector and ack");
      ovf_flag = 1'b0;
      expect_rd(4'hF, 16'h0000, 1'b0, "R8 vector empty");

      // R11 compare event beats a write clearing the flag
      @(posedge clk); #2;
      cnt_tick = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 16'h0010;
      @(posedge clk); #2;
      cnt_tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
      expect_rd(4'h0, 16'h0419, 1'b0, "R11 event wins over write");
      @(posedge clk); #2; irq0_ack = 1'b1;
      @(posedge clk); #2; irq0_ack = 1'b0;

      // R5 falling software capture, R9 vector write clears
      bus_write(4'h2, 16'hA110);
      expect_rd(4'h2, 16'hA111, 1'b0, "R5 falling software capture");
      expect_rd(4'hA, 16'h0042, 1'b0, "R2 data from software capture");
      bus_write(4'hF, 16'h0000);
      expect_rd(4'h2, 16'hA110, 1'b0, "R9 vector write clears ch2");
      expect_irq(1'b0, 1'b0, "R10 all quiet");

      idle(2);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule